// File: doc/BRIEF.md
# Branch Hint Generator

This block sits next to the instruction fetch controller of a pipelined processor that has a decode stage and an execute stage. In every cycle it receives class flags for the instruction in decode and the instruction entering execute. From these it drives a registered 4-bit hint that tells the fetch side where a change of flow is coming from. Decode-stage hints separate backward conditional branches, other conditional branches and unconditional branches. Execute-stage hints separate conditional from unconditional program-counter writes, and they stay up while the execute stage is stalled.

One cycle after a conditional decode hint, the block reports whether that branch was taken. It does this with a dedicated code that comes straight from a flop, so a memory controller can use it as an address-mux select. A second registered output asks the fetch engine to hold off while a multi-cycle load/store that writes the program counter sits in execute.

The instruction decoder supplies the class flags. Two groups of instructions are presented on the decode inputs as unconditional branches: moves or exchanges to the PC from the link register, and branches with link. Register branches through any other register, ALU writes to the PC and load/store writes to the PC are presented on the execute inputs.

Top module: `branch_hint_gen`

## Requirements
- R1: `hint` only ever takes the values 0000, 0001, 0010, 0011, 0100, 0101 and 1000. It never shows 0110, 0111 or any other value with bit 3 set.
- R2: A decode branch (`decValid`=1) with `decCond`=1 and `decInIt`=0 gives 0001 when `decBackward`=1 and 0010 when `decBackward`=0.
- R3: Any decode branch with `decInIt`=1 gives 0010, whatever the values of `decCond` and `decBackward`.
- R4: A decode branch with `decCond`=0 and `decInIt`=0 gives 0100.
- R5: An execute entry (`exValid`=1) with `exCbz`=0 gives 0101 when `exInIt`=0 and 0011 when `exInIt`=1.
- R6: An execute entry with `exCbz`=1 gives 0011, whatever the value of `exInIt`.
- R7: Every hint appears on the cycle after its inputs are sampled. A decode hint lasts exactly one cycle. With no eligible source, the output is 0000.
- R8: After an execute hint, each cycle with `exStall`=1 and `exValid`=0 repeats the same execute code on the next cycle.
- R9: Code 1000 appears in the cycle right after `hint` shows 0001 or 0010, and only if `brTaken` was 1 during that hint cycle. It appears at no other time.
- R10: Priority, from highest to lowest: a pending 1000, then an execute hint (new or held), then a decode hint.
- R11: `fetchSuppress` is 1 in exactly those cycles where `hint` shows 0101 for an execute entry that had `exLsu`=1, including the held stall cycles.
- R12: A synchronous active-high `rst` sets `hint` to 0000 and `fetchSuppress` to 0, and it clears any pending taken report and any held execute hint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| decValid | input | 1 | A branch-class instruction is in decode this cycle |
| decCond | input | 1 | The decode branch is conditional |
| decBackward | input | 1 | The decode branch target lies below the current PC |
| decInIt | input | 1 | The decode instruction is inside a conditional-execution block |
| exValid | input | 1 | A PC-writing instruction enters execute this cycle |
| exCbz | input | 1 | The execute entry is a compare-and-branch-on-zero |
| exLsu | input | 1 | The execute entry is a load/store that writes the PC |
| exInIt | input | 1 | The execute entry is inside a conditional-execution block |
| exStall | input | 1 | The preceding instruction stalls execute this cycle |
| brTaken | input | 1 | The conditional decode branch being hinted was taken |
| hint | output | 4 | Registered branch hint code |
| fetchSuppress | output | 1 | Registered request to hold fetches during a multi-cycle load/store PC write |

## Verification
A corrupted pending-taken state shows up one cycle after the faulty edge. The port would then either skip 1000 after a taken conditional hint or show 1000 when no conditional hint came before it. A stale held-execute state shows up as an execute code that outlives its stall, or as a hold that ends one cycle early. In both cases the error is visible within one cycle of the first affected stall edge. A lost load/store flag shows up in the same cycle as `fetchSuppress` disagreeing with a 0101 hint, so every internal fault appears at the ports within one or two cycles of the cause.

// File: rtl/branch_hint_pkg.sv
package branch_hint_pkg;

  localparam int HINT_W = 4;

  typedef enum logic [HINT_W-1:0] {
    HINT_NONE       = 4'b0000,
    HINT_DEC_BACK   = 4'b0001,
    HINT_DEC_COND   = 4'b0010,
    HINT_EX_COND    = 4'b0011,
    HINT_DEC_UNCOND = 4'b0100,
    HINT_EX_UNCOND  = 4'b0101,
    HINT_TAKEN      = 4'b1000
  } hint_e;

  // strobes from control to datapath, one decision per cycle
  typedef struct packed {
    logic takeSel;   // report a taken conditional decode branch
    logic exNew;     // a new execute entry supplies the code
    logic exHold;    // the held execute code is repeated
    logic decSel;    // decode code is selected
    logic suppress;  // a load/store PC write is active in execute
  } hint_strobe_t;

endpackage

// File: rtl/hint_ctrl.sv
module hint_ctrl
  import branch_hint_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         decValid,
  input  logic         exValid,
  input  logic         exLsu,
  input  logic         exStall,
  input  logic         brTaken,
  input  logic         condDecShown,
  output hint_strobe_t strobe
);

  logic exActiveQ;
  logic exLsuQ;
  logic exAny;
  logic lsuNow;

  always_comb begin
    strobe         = '0;
    strobe.takeSel = condDecShown & brTaken;
    strobe.exNew   = exValid;
    strobe.exHold  = ~exValid & exStall & exActiveQ;
    exAny          = strobe.exNew | strobe.exHold;
    strobe.decSel  = decValid & ~exAny & ~strobe.takeSel;
    lsuNow         = exValid ? exLsu : (strobe.exHold & exLsuQ);
    strobe.suppress = lsuNow & ~strobe.takeSel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exActiveQ <= 1'b0;
      exLsuQ    <= 1'b0;
    end else begin
      exActiveQ <= exAny;
      exLsuQ    <= lsuNow;
    end
  end

endmodule

// File: rtl/hint_path.sv
module hint_path
  import branch_hint_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  hint_strobe_t      strobe,
  input  logic              decCond,
  input  logic              decBackward,
  input  logic              decInIt,
  input  logic              exCbz,
  input  logic              exInIt,
  output logic [HINT_W-1:0] hint,
  output logic              fetchSuppress,
  output logic              condDecShown
);

  hint_e hintQ;
  hint_e hintNext;
  hint_e exCodeQ;
  hint_e exCodeNow;
  hint_e exEnc;
  hint_e decEnc;
  logic  supQ;

  always_comb begin
    exEnc = (exCbz | exInIt) ? HINT_EX_COND : HINT_EX_UNCOND;
    if (decInIt)          decEnc = HINT_DEC_COND;
    else if (!decCond)    decEnc = HINT_DEC_UNCOND;
    else if (decBackward) decEnc = HINT_DEC_BACK;
    else                  decEnc = HINT_DEC_COND;
    exCodeNow = strobe.exNew ? exEnc : exCodeQ;
  end

  always_comb begin
    if (strobe.takeSel)                     hintNext = HINT_TAKEN;
    else if (strobe.exNew | strobe.exHold)  hintNext = exCodeNow;
    else if (strobe.decSel)                 hintNext = decEnc;
    else                                    hintNext = HINT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hintQ   <= HINT_NONE;
      exCodeQ <= HINT_NONE;
      supQ    <= 1'b0;
    end else begin
      hintQ   <= hintNext;
      exCodeQ <= exCodeNow;
      supQ    <= strobe.suppress & (hintNext == HINT_EX_UNCOND);
    end
  end

  assign hint          = hintQ;
  assign fetchSuppress = supQ;
  assign condDecShown  = (hintQ == HINT_DEC_BACK) || (hintQ == HINT_DEC_COND);

endmodule

// File: rtl/branch_hint_gen.sv
module branch_hint_gen
  import branch_hint_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              decValid,
  input  logic              decCond,
  input  logic              decBackward,
  input  logic              decInIt,
  input  logic              exValid,
  input  logic              exCbz,
  input  logic              exLsu,
  input  logic              exInIt,
  input  logic              exStall,
  input  logic              brTaken,
  output logic [HINT_W-1:0] hint,
  output logic              fetchSuppress
);

  hint_strobe_t strobe;
  logic         condDecShown;

  hint_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .decValid     (decValid),
    .exValid      (exValid),
    .exLsu        (exLsu),
    .exStall      (exStall),
    .brTaken      (brTaken),
    .condDecShown (condDecShown),
    .strobe       (strobe)
  );

  hint_path u_path (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .decCond       (decCond),
    .decBackward   (decBackward),
    .decInIt       (decInIt),
    .exCbz         (exCbz),
    .exInIt        (exInIt),
    .hint          (hint),
    .fetchSuppress (fetchSuppress),
    .condDecShown  (condDecShown)
  );

endmodule

// File: rtl/branch_hint_chk.sv
module branch_hint_chk (
  input logic       clk,
  input logic       rst,
  input logic       exValid,
  input logic       exStall,
  input logic       brTaken,
  input logic [3:0] hint,
  input logic       fetchSuppress
);

  // R1: only legal codes leave the block
  p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
    (hint <= 4'b0101) || (hint == 4'b1000));

  // R9: a taken conditional decode hint is followed by 1000
  p_taken_follows_r9: assert property (@(posedge clk) disable iff (rst)
    ((hint == 4'b0001 || hint == 4'b0010) && brTaken) |=> (hint == 4'b1000));

  // R9: 1000 only after a conditional decode hint that was taken
  p_taken_cause_r9: assert property (@(posedge clk) disable iff (rst)
    (hint == 4'b1000) |-> (($past(hint) == 4'b0001 || $past(hint) == 4'b0010) && $past(brTaken)));

  // R8: an execute hint repeats across a stall
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ((hint == 4'b0011 || hint == 4'b0101) && exStall && !exValid) |=> (hint == $past(hint)));

  // R10: a new execute entry beats decode when no taken report is due
  p_ex_priority_r10: assert property (@(posedge clk) disable iff (rst)
    (exValid && !((hint == 4'b0001 || hint == 4'b0010) && brTaken))
      |=> (hint == 4'b0011 || hint == 4'b0101));

  // R11: suppression only alongside the unconditional execute code
  p_suppress_code_r11: assert property (@(posedge clk) disable iff (rst)
    fetchSuppress |-> (hint == 4'b0101));

endmodule

bind branch_hint_gen branch_hint_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .exValid       (exValid),
  .exStall       (exStall),
  .brTaken       (brTaken),
  .hint          (hint),
  .fetchSuppress (fetchSuppress)
);

// File: tb/sim_branch_hint_gen.sv
`timescale 1ns/1ps
module sim_branch_hint_gen;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic decValid = 0, decCond = 0, decBackward = 0, decInIt = 0;
  logic exValid = 0, exCbz = 0, exLsu = 0, exInIt = 0, exStall = 0, brTaken = 0;
  logic [3:0] hint;
  logic fetchSuppress;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [3:0] mHint;
  logic [3:0] mExCode;
  logic       mExAct;
  logic       mLsu;

  always #2.5 clk = ~clk;

  branch_hint_gen u0 (
    .clk(clk), .rst(rst),
    .decValid(decValid), .decCond(decCond), .decBackward(decBackward), .decInIt(decInIt),
    .exValid(exValid), .exCbz(exCbz), .exLsu(exLsu), .exInIt(exInIt),
    .exStall(exStall), .brTaken(brTaken),
    .hint(hint), .fetchSuppress(fetchSuppress)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    report();
  end

  task automatic check(input string tag, input logic [3:0] gotH, input logic [3:0] expH,
                       input logic gotS, input logic expS);
    checks++;
    if (gotH !== expH || gotS !== expS) begin
      errors++;
      $display("FAIL %s: hint=%b sup=%b expected hint=%b sup=%b", tag, gotH, gotS, expH, expS);
    end
  endtask

  task automatic modelReset();
    mHint = 4'b0000; mExCode = 4'b0000; mExAct = 1'b0; mLsu = 1'b0;
  endtask

  // one clock: inputs are already applied; predict, clock, compare away from the edge
  task automatic step();
    logic take, exHold, exAny, lsuNow;
    logic [3:0] exCode, expH;
    logic expS;
    string tag;
    take   = (mHint == 4'b0001 || mHint == 4'b0010) && brTaken;
    exHold = !exValid && exStall && mExAct;
    exAny  = exValid || exHold;
    exCode = exValid ? ((exCbz || exInIt) ? 4'b0011 : 4'b0101) : mExCode;
    lsuNow = exValid ? exLsu : (exHold && mLsu);
    if (take) begin
      expH = 4'b1000; tag = (exAny || decValid) ? "R10 taken first" : "R9 taken report";
    end else if (exValid) begin
      expH = exCode;
      tag = decValid ? "R10 execute over decode" : (exCbz ? "R6 cbz" : "R5 execute class");
    end else if (exHold) begin
      expH = mExCode; tag = "R8 stall hold";
    end else if (decValid) begin
      if (decInIt)          begin expH = 4'b0010; tag = "R3 decode in block"; end
      else if (!decCond)    begin expH = 4'b0100; tag = "R4 decode unconditional"; end
      else if (decBackward) begin expH = 4'b0001; tag = "R2 decode backward"; end
      else                  begin expH = 4'b0010; tag = "R2 decode forward"; end
    end else begin
      expH = 4'b0000; tag = "R7 idle";
    end
    expS = lsuNow && !take && exAny && (exCode == 4'b0101);
    if (expS) tag = {tag, " / R11 suppress"};
    mExAct = exAny; mExCode = exCode; mLsu = lsuNow; mHint = expH;
    @(posedge clk);
    @(negedge clk);
    check(tag, hint, expH, fetchSuppress, expS);
    checks++;
    if (hint == 4'b0110 || hint == 4'b0111 || (hint[3] && hint != 4'b1000)) begin
      errors++;
      $display("FAIL R1: illegal hint=%b expected a defined code", hint);
    end
  endtask

  task automatic idle();
    decValid = 0; exValid = 0; exStall = 0; brTaken = 0;
    decCond = 0; decBackward = 0; decInIt = 0; exCbz = 0; exLsu = 0; exInIt = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    idle();
    rst = 1;
    modelReset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R12 reset", hint, 4'b0000, fetchSuppress, 1'b0);
    rst = 0;

    // decode sweep: every class flag combination, taken and not taken
    for (int d = 0; d < 8; d++) begin
      for (int t = 0; t < 2; t++) begin
        idle();
        decValid = 1; decCond = d[0]; decBackward = d[1]; decInIt = d[2];
        step();
        idle(); brTaken = t[0];
        step();   // R7: decode hint gone after one cycle, R9 taken code
        idle();
        step();
      end
    end

    // execute sweep: every class combination with stall lengths 0..3
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 4; s++) begin
        idle();
        exValid = 1; exCbz = e[0]; exLsu = e[1]; exInIt = e[2];
        step();
        for (int k = 0; k < s; k++) begin
          idle(); exStall = 1;
          step();
        end
        idle();
        step();
        step();
      end
    end

    // R10: decode and execute together, and a taken report during a hold
    idle(); decValid = 1; decCond = 1; decBackward = 1; exValid = 1; exLsu = 1;
    step();
    idle(); decValid = 1; decCond = 1;
    step();
    idle(); exValid = 1; exLsu = 1; brTaken = 1;
    step();
    idle(); exStall = 1; brTaken = 1; decValid = 1;
    step();
    idle(); exStall = 1;
    step();
    idle();
    step();

    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      decValid = lfsr[0]; decCond = lfsr[1]; decBackward = lfsr[2]; decInIt = lfsr[3];
      exValid = lfsr[4] & lfsr[5]; exCbz = lfsr[6] & lfsr[7]; exLsu = lfsr[8];
      exInIt = lfsr[9] & lfsr[10]; exStall = lfsr[11] | lfsr[12]; brTaken = lfsr[13];
      if (i == 2500) begin
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        modelReset();
        check("R12 reset midrun", hint, 4'b0000, fetchSuppress, 1'b0);
      end else begin
        step();
      end
    end

    idle();
    step();
    report();
  end

endmodule